// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block takes two 64-bit operands, an operation code and an operand size. It returns the result of an add, subtract or bitwise logic operation, cut down to the selected size, together with a 12-bit status word. Each flag in that word has a fixed bit position. The arithmetic side computes carry, half-carry and signed overflow at the chosen operand width. The logic side clears those three flags and derives zero, sign and parity from its result. The three control bits (single-step, interrupt enable, string direction) do not come from the computation. They are copied unchanged from a dedicated input.

The status word is produced combinationally every cycle. A registered copy of it loads on a clock edge only when the update strobe is high. The surrounding pipeline can therefore compute flags for any operation and choose whether that operation commits them.

Top module: `status_flag_unit`

## Requirements
- R1: `result` holds the operation's outcome truncated to the width picked by `opsize` (0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = 64 bit). All bits above that width read as zero, and operand bits above that width have no effect.
- R2: `op` selects 0 = add, 1 = add with carry, 2 = subtract, 3 = subtract with borrow, 4 = AND, 5 = OR, 6 and 7 = XOR. Bit 0 of `flags` is the carry out of the top bit of the selected width for add, or the borrow out of the top bit for subtract.
- R3: Bit 2 of `flags` is 1 exactly when result bits 7..0 hold an even number of ones, at every operand size.
- R4: Bit 4 of `flags` is the carry (add) or borrow (subtract) out of bit 3.
- R5: Bit 6 of `flags` is 1 exactly when the truncated result is zero.
- R6: Bit 7 of `flags` equals the most significant bit of the truncated result at the selected width.
- R7: Bit 11 of `flags` is 1 on signed overflow at the selected width (two's complement).
- R8: Bits 10..8 of `flags` equal `ctrl_in[2:0]` for every operation. Bit 1 is always 1, and bits 3 and 5 are always 0.
- R9: For the logic operations (codes 4 to 7), bits 0, 4 and 11 of `flags` are 0.
- R10: `flags_q` loads `flags` on a rising clock edge when `upd_en` is 1 and otherwise holds its value. Asynchronous active-low reset sets it to 0x002.
- R11: `carry_in` is added only by code 1 and subtracted only by code 3. It has no effect on any other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| carry_in | input | 1 | Incoming carry / borrow |
| op | input | 3 | Operation code |
| opsize | input | 2 | Operand size code |
| ctrl_in | input | 3 | Control bits copied to flag bits 10..8 |
| upd_en | input | 1 | Load strobe for the registered flag word |
| result | output | 64 | Size-truncated result |
| flags | output | 12 | Combinational status word |
| flags_q | output | 12 | Registered status word |

## Verification
Everything except `flags_q` is combinational, so a wrong size mask or a misplaced carry tap shows up in `result` and `flags` during the same cycle the operands are applied. The registered copy is the only state in the block. Loading it when it should hold, or holding it when it should load, becomes visible on `flags_q` one clock edge after the strobe. A failed reset becomes visible before the first update. The tests look for these faults with vectors at every width: carries and borrows at the top bit of each width, half-carries, overflow into the sign bit, parity with busy upper bytes, and strobe-low cycles between loads.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

    localparam int DATA_W  = 64;
    localparam int FLAG_W  = 12;
    localparam int CTRL_W  = 3;
    localparam int OP_W    = 3;
    localparam int SIZE_W  = 2;
    localparam logic [FLAG_W-1:0] FLAG_RST = 12'h002;

    localparam int POS_CY  = 0;
    localparam int POS_ONE = 1;
    localparam int POS_PAR = 2;
    localparam int POS_HC  = 4;
    localparam int POS_ZR  = 6;
    localparam int POS_NEG = 7;
    localparam int POS_CTL = 8;
    localparam int POS_OVF = 11;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_XOR2 = 3'd7
    } op_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } state_t;

    function automatic logic [DATA_W-1:0] width_mask(input logic [SIZE_W-1:0] sz);
        logic [DATA_W-1:0] m;
        m = '1;
        case (sz)
            2'd0:    m = {{(DATA_W-8){1'b0}},  {8{1'b1}}};
            2'd1:    m = {{(DATA_W-16){1'b0}}, {16{1'b1}}};
            2'd2:    m = {{(DATA_W-32){1'b0}}, {32{1'b1}}};
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic int top_bit(input logic [SIZE_W-1:0] sz);
        return (8 << sz) - 1;
    endfunction

endpackage

// File: rtl/sfg_arith.sv
module sfg_arith
    import sfg_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cy_o,
    output logic              hc_o,
    output logic              ovf_o
);

    logic [DATA_W:0] wide;
    logic            sa, sb, sr;

    always_comb begin
        if (sub_i) begin
            wide = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
        end else begin
            wide = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
        end
        // operands are pre-masked, so bit W of the wide value is the carry/borrow at width W
        cy_o = wide[top_bit(size_i) + 1];
        hc_o = a_i[4] ^ b_i[4] ^ wide[4];
        sa   = a_i[top_bit(size_i)];
        sb   = b_i[top_bit(size_i)];
        sr   = wide[top_bit(size_i)];
        if (sub_i) begin
            ovf_o = (sa != sb) && (sr != sa);
        end else begin
            ovf_o = (sa == sb) && (sr != sa);
        end
        sum_o = wide[DATA_W-1:0] & width_mask(size_i);
    end

endmodule

// File: rtl/sfg_logic.sv
module sfg_logic
    import sfg_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [1:0]        fn_i,
    output logic [DATA_W-1:0] res_o
);

    always_comb begin
        case (fn_i)
            2'd0:    res_o = a_i & b_i;
            2'd1:    res_o = a_i | b_i;
            default: res_o = a_i ^ b_i;
        endcase
    end

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
    import sfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       opnd_a,
    input  logic [63:0]       opnd_b,
    input  logic              carry_in,
    input  logic [2:0]        op,
    input  logic [1:0]        opsize,
    input  logic [2:0]        ctrl_in,
    input  logic              upd_en,
    output logic [63:0]       result,
    output logic [11:0]       flags,
    output logic [11:0]       flags_q
);

    state_t            st_d, st_q;
    logic [DATA_W-1:0] a_m, b_m;
    logic [DATA_W-1:0] ar_sum, lg_res, res_w;
    logic              ar_cy, ar_hc, ar_ovf;
    logic              is_logic, is_sub, use_cin;
    logic [FLAG_W-1:0] fl_w;

    assign a_m      = opnd_a & width_mask(opsize);
    assign b_m      = opnd_b & width_mask(opsize);
    assign is_logic = op[2];
    assign is_sub   = op[1] & ~op[2];
    assign use_cin  = op[0] & ~op[2];

    sfg_arith u_arith (
        .a_i    (a_m),
        .b_i    (b_m),
        .cin_i  (carry_in & use_cin),
        .sub_i  (is_sub),
        .size_i (opsize),
        .sum_o  (ar_sum),
        .cy_o   (ar_cy),
        .hc_o   (ar_hc),
        .ovf_o  (ar_ovf)
    );

    sfg_logic u_logic (
        .a_i  (a_m),
        .b_i  (b_m),
        .fn_i (op[1:0]),
        .res_o(lg_res)
    );

    always_comb begin
        res_w = is_logic ? lg_res : ar_sum;
        fl_w  = '0;
        fl_w[POS_CY]              = ~is_logic & ar_cy;
        fl_w[POS_ONE]             = 1'b1;
        fl_w[POS_PAR]             = ~^res_w[7:0];
        fl_w[POS_HC]              = ~is_logic & ar_hc;
        fl_w[POS_ZR]              = (res_w == '0);
        fl_w[POS_NEG]             = res_w[top_bit(opsize)];
        fl_w[POS_CTL+CTRL_W-1:POS_CTL] = ctrl_in;
        fl_w[POS_OVF]             = ~is_logic & ar_ovf;

        st_d = st_q;
        if (upd_en) begin
            st_d.flags = fl_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= FLAG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign result  = res_w;
    assign flags   = fl_w;
    assign flags_q = st_q.flags;

endmodule

// File: rtl/sfg_checker.sv
module sfg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  op,
    input logic [1:0]  opsize,
    input logic [2:0]  ctrl_in,
    input logic        upd_en,
    input logic [63:0] result,
    input logic [11:0] flags,
    input logic [11:0] flags_q
);

    AST_CTRL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        flags[10:8] == ctrl_in); // R8

    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        op[2] |-> (flags[0] == 1'b0 && flags[4] == 1'b0 && flags[11] == 1'b0)); // R9

    AST_BYTE_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
        (opsize == 2'd0) |-> (result[63:8] == '0)); // R1

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        flags[6] == (result == '0)); // R5

    AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        flags[7] == ((opsize == 2'd0) ? result[7] : (opsize == 2'd1) ? result[15] :
                     (opsize == 2'd2) ? result[31] : result[63])); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(flags_q)); // R10

    AST_LOAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> flags_q == $past(flags)); // R10

endmodule

bind status_flag_unit sfg_checker chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .opsize  (opsize),
    .ctrl_in (ctrl_in),
    .upd_en  (upd_en),
    .result  (result),
    .flags   (flags),
    .flags_q (flags_q)
);

// File: tb/status_flag_unit_tb_top.sv
module status_flag_unit_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic        carry_in = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  opsize = '0;
    logic [2:0]  ctrl_in = '0;
    logic        upd_en = 1'b0;
    logic [63:0] result;
    logic [11:0] flags, flags_q;

    int n_checks = 0;
    int n_fail   = 0;
    logic [11:0] exp_q = 12'h002;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    typedef struct {
        logic [63:0] res;
        logic [11:0] fl;
        logic [11:0] fq;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    status_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .carry_in(carry_in), .op(op), .opsize(opsize), .ctrl_in(ctrl_in),
        .upd_en(upd_en), .result(result), .flags(flags), .flags_q(flags_q)
    );

    // ripple-carry reference written from the requirements
    function automatic logic [75:0] ref_model(input logic [63:0] a, input logic [63:0] b,
                                              input logic cin, input logic [2:0] o,
                                              input logic [1:0] sz, input logic [2:0] ctl);
        int          w = 8 << sz;
        logic [63:0] r = '0;
        logic        c, c4 = 1'b0, cmsb = 1'b0, bb, sub;
        logic        cf = 1'b0, af = 1'b0, ovf = 1'b0;
        logic [11:0] f;
        if (o < 3'd4) begin
            sub = o[1];
            c   = sub ? ~(o[0] & cin) : (o[0] & cin);
            for (int i = 0; i < w; i++) begin
                bb   = sub ? ~b[i] : b[i];
                r[i] = a[i] ^ bb ^ c;
                if (i == w - 1) cmsb = c;
                c = (a[i] & bb) | (a[i] & c) | (bb & c);
                if (i == 3) c4 = c;
            end
            cf  = sub ? ~c : c;
            af  = sub ? ~c4 : c4;
            ovf = cmsb ^ c;
        end else begin
            for (int i = 0; i < w; i++) begin
                case (o)
                    3'd4:    r[i] = a[i] & b[i];
                    3'd5:    r[i] = a[i] | b[i];
                    default: r[i] = a[i] ^ b[i];
                endcase
            end
        end
        f = {ovf, ctl, r[w-1], (r == '0), 1'b0, af, 1'b0, ~^r[7:0], 1'b1, cf};
        return {f, r};
    endfunction

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic cin,
                         input logic [2:0] o, input logic [1:0] sz, input logic [2:0] ctl,
                         input logic en, input string tag);
        logic [75:0] m;
        item_t it;
        @(negedge clk);
        opnd_a = a; opnd_b = b; carry_in = cin; op = o; opsize = sz;
        ctrl_in = ctl; upd_en = en;
        m = ref_model(a, b, cin, o, sz, ctl);
        if (en) exp_q = m[75:64];
        it.res = m[63:0];
        it.fl  = m[75:64];
        it.fq  = exp_q;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: one item per cycle, sampled after the edge that loads flags_q
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check({"R1 result ", it.tag}, result, it.res);
                check({"flags ", it.tag}, {52'b0, flags}, {52'b0, it.fl});
                check({"R10 flags_q ", it.tag}, {52'b0, flags_q}, {52'b0, it.fq});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10 reset value", {52'b0, flags_q}, 64'h002);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R10 reset hold", {52'b0, flags_q}, 64'h002);

        // R1 R2: 8-bit add, carry from bit 7, upper operand bits ignored
        drive(64'hDEAD_BEEF_0000_00F0, 64'h1234_0000_0000_0020, 1'b0, 3'd0, 2'd0, 3'b000, 1'b1, "R2 byte carry");
        // R7: 64-bit signed overflow
        drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 3'd0, 2'd3, 3'b101, 1'b1, "R7 ovf64 R8");
        // R2: 16-bit borrow
        drive(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 1'b0, 3'd2, 2'd1, 3'b010, 1'b0, "R2 borrow16");
        // R4: half carry 0x0F + 0x01
        drive(64'h0F, 64'h01, 1'b0, 3'd0, 2'd2, 3'b000, 1'b1, "R4 half carry");
        // R4: half borrow 0x10 - 0x01
        drive(64'h10, 64'h01, 1'b0, 3'd2, 2'd0, 3'b111, 1'b0, "R4 half borrow");
        // R11: add with carry vs plain add ignoring carry_in
        drive(64'hFFFF_FFFF, 64'h0, 1'b1, 3'd1, 2'd2, 3'b000, 1'b1, "R11 adc R5 zero");
        drive(64'hFFFF_FFFF, 64'h0, 1'b1, 3'd0, 2'd2, 3'b000, 1'b1, "R11 add ignores cin");
        drive(64'h0, 64'h0, 1'b1, 3'd3, 2'd3, 3'b000, 1'b0, "R11 sbb borrow R6");
        drive(64'h5, 64'h5, 1'b1, 3'd2, 2'd0, 3'b000, 1'b1, "R11 sub ignores cin R5");
        // R3: parity of low byte only, busy upper bytes
        drive(64'hFFFF_FFFF_FFFF_FF00, 64'h0000_0000_0000_0003, 1'b0, 3'd5, 2'd3, 3'b000, 1'b1, "R3 parity even");
        drive(64'hFFFF_FFFF_FFFF_FF00, 64'h0000_0000_0000_0001, 1'b0, 3'd5, 2'd3, 3'b000, 1'b0, "R3 parity odd");
        // R9: logic ops clear carry, half carry, overflow
        drive(64'hFF, 64'hFF, 1'b1, 3'd4, 2'd0, 3'b001, 1'b1, "R9 and R6 sign8");
        drive(64'hFFFF, 64'hFFFF, 1'b1, 3'd6, 2'd1, 3'b100, 1'b1, "R9 xor R5 zero");
        drive(64'h8000, 64'h0, 1'b0, 3'd7, 2'd1, 3'b010, 1'b1, "R9 xor alt R6 sign16");
        // R7: subtract overflow at 32 bits
        drive(64'h8000_0000, 64'h1, 1'b0, 3'd2, 2'd2, 3'b000, 1'b1, "R7 sub ovf32");
        // R10: strobe low keeps old value across changing flags
        drive(64'h1, 64'h1, 1'b0, 3'd0, 2'd0, 3'b111, 1'b0, "R10 hold R8");
        drive(64'h80, 64'h80, 1'b0, 3'd0, 2'd0, 3'b000, 1'b0, "R10 hold again");

        for (int k = 0; k < 400; k++) begin
            logic [63:0] ra, rb;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            ra = lfsr;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            rb = lfsr ^ {lfsr[31:0], lfsr[63:32]};
            drive(ra, rb, ra[5], ra[2:0] ^ rb[9:7], rb[1:0], rb[12:10], ra[20],
                  "R1 R2 R3 R4 R5 R6 R7 R9 random");
        end

        @(negedge clk);
        upd_en = 1'b0;
        wait (sb_q.size() == 0);
        @(negedge clk);
        finish_run();
    end

endmodule